// File: doc/BRIEF.md
# Coincident-Selection RAM Array

This block is a small random-access memory whose storage cells sit in a two-dimensional grid. It does not use one decoder that turns the whole address into a single word line. The upper address bits drive a row decoder and the lower bits drive a column decoder. The column decoder has an enable input, and chip select drives it. A cell takes part in an access only where its active row line crosses its active column line. When a word holds more than one bit, each column select covers a group of adjacent physical columns, one column per data bit.

Each cycle, the chip select and read/write inputs pick one of three access modes. IDLE is chip select low. READ is chip select high with read/write high. WRITE is chip select high with read/write low. The mode follows the inputs directly in every cycle, with no stored sequence, so any mode can follow any other. A read is combinational. A write is stored at the rising clock edge. In a cycle that does not read, the data output is undriven: a drive flag stays low and the data lines are held at zero, which stands for high impedance.

Top module: `crs_ram`

## Requirements
- R1: While reset is active, every cell is cleared to 0, so each address reads back all zeros after reset.
- R2: The address splits into a row field in its upper ROW_BITS bits and a column field in its lower COL_BITS bits. In the default 16x1 grid, address a lands in row a/4 and column a%4, so addresses 0, 4, 8 and 12 share the first column.
- R3: Exactly one row line is active in every cycle.
- R4: With chip select low, no column line is active. With chip select high, exactly one column line is active.
- R5: In a WRITE cycle (chip select 1, read/write 0), the word at the address takes the data input at the rising clock edge. No other cell changes.
- R6: In a READ cycle (chip select 1, read/write 1), the output carries the stored word at the address in the same cycle, and the drive flag is 1.
- R7: In IDLE (chip select 0), the drive flag is 0, the output is 0, and no cell changes, whatever read/write and the data input are doing.
- R8: In a WRITE cycle, the drive flag is 0 and the output is 0.
- R9: When DATA_BITS is greater than 1, each data bit of a word is stored in its own column of the selected group, and each bit reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the grid |
| cs | input | 1 | Chip select; enables the column decoder |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ROW_BITS+COL_BITS | Word address, row field above column field |
| din | input | DATA_BITS | Write data |
| dout | output | DATA_BITS | Read data; 0 when not driven |
| dout_en | output | 1 | 1 = dout valid, 0 = high impedance |

## Verification
The bench targets address aliasing with a walking-one sweep. It writes a single set word, then reads every other address. A swapped row and column field, or a decoder that raises two lines, would show that word at a second address or destroy another word. It runs IDLE cycles with write asserted and changing data, then reads the whole pattern back. A column decoder that ignores chip select would corrupt memory there or drive the output. It also samples the drive flag during writes, and reads a two-bit-word configuration with alternating bit patterns. A misplaced column group would swap or smear those bits.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_READ  = 2'd1,
        MODE_WRITE = 2'd2
    } crs_mode_e;
endpackage

// File: rtl/crs_row_decoder.sv
module crs_row_decoder #(
    parameter int ROW_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ROW_BITS-1:0]       row_addr,
    output logic [(1<<ROW_BITS)-1:0]  row_sel
);
    localparam int ROWS = 1 << ROW_BITS;

    always_comb begin
        row_sel = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_addr == ROW_BITS'(r)) row_sel[r] = 1'b1;
        end
    end

    // R3: one row line per cycle
    assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);
endmodule

// File: rtl/crs_col_decoder.sv
module crs_col_decoder #(
    parameter int COL_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [COL_BITS-1:0]       col_addr,
    output logic [(1<<COL_BITS)-1:0]  col_sel
);
    localparam int COLS = 1 << COL_BITS;

    always_comb begin
        col_sel = '0;
        if (en) begin
            for (int c = 0; c < COLS; c++) begin
                if (col_addr == COL_BITS'(c)) col_sel[c] = 1'b1;
            end
        end
    end

    assert_col_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (col_sel == '0));
    assert_col_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(col_sel) == 1));
endmodule

// File: rtl/crs_cell_array.sv
module crs_cell_array #(
    parameter int ROW_BITS  = 2,
    parameter int COL_BITS  = 2,
    parameter int DATA_BITS = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(1<<ROW_BITS)-1:0]  row_sel,
    input  logic [(1<<COL_BITS)-1:0]  col_sel,
    input  logic                      wr_en,
    input  logic [DATA_BITS-1:0]      wr_data,
    output logic [DATA_BITS-1:0]      rd_data
);
    localparam int ROWS      = 1 << ROW_BITS;
    localparam int COLS      = 1 << COL_BITS;
    localparam int PHYS_COLS = COLS * DATA_BITS;
    localparam int CELLS     = ROWS * PHYS_COLS;

    logic [CELLS-1:0] cell_q;

    // Each cell updates only where its row and column lines cross.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (row_sel[r] && col_sel[c]) begin
                        cell_q[r*PHYS_COLS + c*DATA_BITS +: DATA_BITS] <= wr_data;
                    end
                end
            end
        end
    end

    // AND-OR read network across the grid.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (row_sel[r] && col_sel[c]) begin
                    rd_data = rd_data | cell_q[r*PHYS_COLS + c*DATA_BITS +: DATA_BITS];
                end
            end
        end
    end

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cell_q));
    assert_one_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ($countones(cell_q ^ $past(cell_q)) <= DATA_BITS));
endmodule

// File: rtl/crs_ram.sv
module crs_ram #(
    parameter int ROW_BITS  = 2,
    parameter int COL_BITS  = 2,
    parameter int DATA_BITS = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs,
    input  logic                           rw,
    input  logic [ROW_BITS+COL_BITS-1:0]   addr,
    input  logic [DATA_BITS-1:0]           din,
    output logic [DATA_BITS-1:0]           dout,
    output logic                           dout_en
);
    import crs_pkg::*;

    localparam int ADDR_W = ROW_BITS + COL_BITS;
    localparam int ROWS   = 1 << ROW_BITS;
    localparam int COLS   = 1 << COL_BITS;

    crs_mode_e                mode;
    logic [ROW_BITS-1:0]      row_addr;
    logic [COL_BITS-1:0]      col_addr;
    logic [ROWS-1:0]          row_sel;
    logic [COLS-1:0]          col_sel;
    logic                     wr_en;
    logic [DATA_BITS-1:0]     rd_data;

    assign row_addr = addr[ADDR_W-1:COL_BITS];
    assign col_addr = addr[COL_BITS-1:0];

    // Mode decode
    always_comb begin
        unique case ({cs, rw})
            2'b11:   mode = MODE_READ;
            2'b10:   mode = MODE_WRITE;
            default: mode = MODE_IDLE;
        endcase
    end

    // Outputs by mode
    always_comb begin
        wr_en   = 1'b0;
        dout_en = 1'b0;
        dout    = '0;
        unique case (mode)
            MODE_READ: begin
                dout_en = 1'b1;
                dout    = rd_data;
            end
            MODE_WRITE: wr_en = 1'b1;
            default: ;
        endcase
    end

    crs_row_decoder #(.ROW_BITS(ROW_BITS)) u_row_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_addr (row_addr),
        .row_sel  (row_sel)
    );

    crs_col_decoder #(.COL_BITS(COL_BITS)) u_col_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cs),
        .col_addr (col_addr),
        .col_sel  (col_sel)
    );

    crs_cell_array #(
        .ROW_BITS  (ROW_BITS),
        .COL_BITS  (COL_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .wr_en   (wr_en),
        .wr_data (din),
        .rd_data (rd_data)
    );

    assert_idle_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (!dout_en && dout == '0));
    assert_write_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !rw) |-> (!dout_en && dout == '0));
    assert_read_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rw) |-> dout_en);
endmodule

// File: tb/crs_ram_bench.sv
module crs_ram_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       rw = 1'b1;
    logic [3:0] addr = '0;
    logic       din_a = 1'b0;
    logic [1:0] din_b = '0;
    logic       dout_a, en_a;
    logic [1:0] dout_b;
    logic       en_b;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic       mem_a [16];
    logic [1:0] mem_b [8];

    always #4 clk = ~clk;

    crs_ram u_crs_ram (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr),
        .din(din_a), .dout(dout_a), .dout_en(en_a)
    );

    crs_ram #(.ROW_BITS(2), .COL_BITS(1), .DATA_BITS(2)) u_crs_ram_w2 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr[2:0]),
        .din(din_b), .dout(dout_b), .dout_en(en_b)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic da, input logic [1:0] db);
        @(negedge clk);
        cs = 1'b1; rw = 1'b0; addr = a; din_a = da; din_b = db;
        #2;
        check("R8", {31'd0, en_a}, 0, "drive flag during write 16x1");
        check("R8", {30'd0, dout_b} + {31'd0, en_b}, 0, "output during write 8x2");
        mem_a[a] = da;
        mem_b[a[2:0]] = db;
        @(posedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, input string req);
        @(negedge clk);
        cs = 1'b1; rw = 1'b1; addr = a;
        #2;
        check("R6", {31'd0, en_a}, 1, "drive flag on read 16x1");
        check(req, {31'd0, dout_a}, {31'd0, mem_a[a]}, $sformatf("16x1 addr %0d", a));
        check("R9", {30'd0, dout_b}, {30'd0, mem_b[a[2:0]]}, $sformatf("8x2 addr %0d", a[2:0]));
    endtask

    // Chip deselected while write is asserted and data varies.
    task automatic do_idle(input logic [3:0] a, input logic r);
        @(negedge clk);
        cs = 1'b0; rw = r; addr = a; din_a = ~mem_a[a]; din_b = ~mem_b[a[2:0]];
        #2;
        check("R7", {31'd0, en_a} + {31'd0, dout_a}, 0, "idle output 16x1");
        check("R7", {31'd0, en_b} + {30'd0, dout_b}, 0, "idle output 8x2");
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_a[i] = 1'b0;
        for (int i = 0; i < 8; i++) mem_b[i] = 2'b00;
        repeat (3) @(negedge clk);
        check("R7", {31'd0, en_a}, 0, "drive flag in reset");
        rst_n = 1'b1;

        // R1: cleared grid
        for (int i = 0; i < 16; i++) do_read(4'(i), "R1");

        // R2 R3 R4 R5: walking single word, every other address must stay zero
        for (int i = 0; i < 16; i++) begin
            do_write(4'(i), 1'b1, (i >= 8) ? 2'b10 : 2'b01);
            for (int j = 0; j < 16; j++) do_read(4'(j), "R2");
            do_write(4'(i), 1'b0, 2'b00);
        end

        // R2: column-sharing addresses 0,4,8,12 hold distinct values
        do_write(4'd0, 1'b1, 2'b11);
        do_write(4'd4, 1'b0, 2'b01);
        do_write(4'd8, 1'b1, 2'b10);
        do_write(4'd12, 1'b0, 2'b00);
        for (int j = 0; j < 16; j += 4) do_read(4'(j), "R2");

        // R5 R9: full pattern
        for (int i = 0; i < 16; i++) do_write(4'(i), ^(4'(i * 3)), 2'((i * 3 + 1) & 3));
        for (int i = 0; i < 16; i++) do_read(4'(i), "R5");

        // R7: deselected cycles with write asserted, then whole pattern unchanged
        for (int i = 0; i < 16; i++) do_idle(4'(i), 1'b0);
        for (int i = 0; i < 4; i++) do_idle(4'(i), 1'b1);
        for (int i = 0; i < 16; i++) do_read(4'(i), "R7");

        // R5 R9: inverted pattern overwrite
        for (int i = 15; i >= 0; i--) do_write(4'(i), ~mem_a[i], ~mem_b[i & 7]);
        for (int i = 0; i < 16; i++) do_read(4'(i), "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule